// File: doc/BRIEF.md
# Banked Register Map Controller

This block is a byte-wide register file that sits behind a serial-bus front end. The bit-level protocol has already been reduced to four one-cycle strobes: transaction start, transaction stop, write-byte (with its data) and read-byte. The first byte written after a start loads an internal pointer. Every later data byte reads or writes the register at that pointer, and the pointer then steps forward by one, wrapping from 0xFF to 0x00.

The low quarter of the map (0x00 to 0x3F) is common space and is always visible. Bit 5 of the common register 0x0E is a split flag. It chooses whether addresses 0x40 and above reach the main bank (0x40 to 0xFF) or a smaller secondary bank (0x40 to 0x9C). The flag is checked again on every data byte, so a burst that sets it and then carries on above 0x40 lands in the secondary bank. The common space holds a window of read-only identification registers and a window of write-only registers. All storage is a single synchronous memory with the bank select used as the top index bit, so it maps onto one block RAM.

Top module: `regmap_ctrl`

## Requirements
- R1: The first write strobe after a start loads the pointer with its data byte and writes no register.
- R2: Each later data byte accesses the register at the pointer, then the pointer increments by one, wrapping from 0xFF to 0x00. This holds across 0x3F to 0x40.
- R3: A read strobe gives rd_valid high exactly one clock later with the register value on rd_data. rd_valid is low after reset and in every cycle that does not follow a read strobe.
- R4: Addresses 0x00 to 0x3F return the same storage whatever the split flag is.
- R5: The split flag is bit 5 of register 0x0E and resets to 0. With the flag at 0, addresses 0x40 to 0xFF reach the main bank.
- R6: With the flag at 1, addresses 0x40 to 0x9C reach the secondary bank. Reads of 0x9D to 0xFF return 0x00, and writes to them change no storage in either bank.
- R7: Addresses 0x10 to 0x13 are read-only and read as 0xA0 plus (address minus 0x10). Writes to them are ignored.
- R8: Addresses 0x20 to 0x23 are write-only. They accept writes and read as 0x00.
- R9: A write that changes the split flag steers the very next data byte, including later bytes of the same burst.
- R10: Byte strobes outside a transaction (after stop, before the next start) are ignored. A read after a start with no pointer write uses the pointer held from earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Transaction start strobe |
| txn_stop | input | 1 | Transaction stop strobe |
| wr_en | input | 1 | Write-byte strobe |
| wr_data | input | 8 | Byte written with wr_en |
| rd_en | input | 1 | Read-byte strobe |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read data byte |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a secondary bank ending at 0x9C, and the split flag at bit 5 of 0x0E. With these values the full pointer wrap, the crossing from 0x3F to 0x40, both banks and the dead secondary range are all reached in short bursts. A single burst that starts at 0x0E sets the flag and then runs past 0x40. This shows that a flag change takes effect in the middle of a burst, and it also walks through the read-only and write-only windows.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  typedef enum logic [1:0] {K_RW, K_RO, K_WO, K_NONE} kind_e;
endpackage

// File: rtl/regmap_decode.sv
module regmap_decode
  import regmap_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int COMMON_TOP = 'h40,
  parameter int SUB_TOP    = 'h9C,
  parameter int RO_LO      = 'h10,
  parameter int RO_HI      = 'h13,
  parameter int WO_LO      = 'h20,
  parameter int WO_HI      = 'h23
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              split,
  output kind_e             kind,
  output logic              sub_sel
);
  logic common;

  always_comb begin
    common  = addr < ADDR_W'(COMMON_TOP);
    sub_sel = !common && split;
    kind    = K_RW;
    if (common) begin
      if (addr >= ADDR_W'(RO_LO) && addr <= ADDR_W'(RO_HI))      kind = K_RO;
      else if (addr >= ADDR_W'(WO_LO) && addr <= ADDR_W'(WO_HI)) kind = K_WO;
    end else if (split && addr > ADDR_W'(SUB_TOP)) begin
      kind = K_NONE;
    end
  end
endmodule

// File: rtl/regmap_ptr.sv
module regmap_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic              txn_stop,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr_byte,
  input  logic              rd_en,
  output logic [ADDR_W-1:0] ptr,
  output logic              data_wr,
  output logic              data_rd
);
  logic active, expect_ptr;

  assign data_wr = wr_en && active && !expect_ptr;
  assign data_rd = rd_en && active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      expect_ptr <= 1'b0;
      ptr        <= '0;
    end else if (txn_start) begin
      active     <= 1'b1;
      expect_ptr <= 1'b1;
    end else if (txn_stop) begin
      active     <= 1'b0;
      expect_ptr <= 1'b0;
    end else if (wr_en && active && expect_ptr) begin
      ptr        <= wr_addr_byte;
      expect_ptr <= 1'b0;
    end else if (data_wr || data_rd) begin
      ptr <= ptr + 1'b1;
    end
  end

  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && active && expect_ptr && !txn_start && !txn_stop) |=> (ptr == $past(wr_addr_byte)));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((data_wr || data_rd) && !txn_start && !txn_stop) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/regmap_store.sv
module regmap_store #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/regmap_ctrl.sv
module regmap_ctrl
  import regmap_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int COMMON_TOP = 'h40,
  parameter int SUB_TOP    = 'h9C,
  parameter int SPLIT_ADDR = 'h0E,
  parameter int SPLIT_BIT  = 5,
  parameter int RO_LO      = 'h10,
  parameter int RO_HI      = 'h13,
  parameter int WO_LO      = 'h20,
  parameter int WO_HI      = 'h23,
  parameter int ID_BASE    = 'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic              txn_stop,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = ADDR_W + 1;

  logic [ADDR_W-1:0] ptr;
  logic              data_wr, data_rd, sub_sel, split_en, mem_we;
  kind_e             kind, kind_q;
  logic [DATA_W-1:0] ro_val, ro_q, mem_q;

  regmap_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_stop(txn_stop),
    .wr_en(wr_en), .wr_addr_byte(wr_data[ADDR_W-1:0]), .rd_en(rd_en),
    .ptr(ptr), .data_wr(data_wr), .data_rd(data_rd)
  );

  regmap_decode #(
    .ADDR_W(ADDR_W), .COMMON_TOP(COMMON_TOP), .SUB_TOP(SUB_TOP),
    .RO_LO(RO_LO), .RO_HI(RO_HI), .WO_LO(WO_LO), .WO_HI(WO_HI)
  ) u_dec (
    .addr(ptr), .split(split_en), .kind(kind), .sub_sel(sub_sel)
  );

  assign mem_we = data_wr && (kind == K_RW || kind == K_WO);
  assign ro_val = DATA_W'(ID_BASE) + DATA_W'(ptr - ADDR_W'(RO_LO));

  regmap_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(mem_we), .idx({sub_sel, ptr}), .wdata(wr_data),
    .re(data_rd), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      split_en <= 1'b0;
      rd_valid <= 1'b0;
      kind_q   <= K_NONE;
      ro_q     <= '0;
    end else begin
      rd_valid <= data_rd;
      if (data_wr && ptr == ADDR_W'(SPLIT_ADDR)) split_en <= wr_data[SPLIT_BIT];
      if (data_rd) begin
        kind_q <= kind;
        ro_q   <= ro_val;
      end
    end
  end

  always_comb begin
    case (kind_q)
      K_RW:    rd_data = mem_q;
      K_RO:    rd_data = ro_q;
      default: rd_data = '0;
    endcase
  end

  // R3
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R6
  unimpl_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (split_en && data_wr && ptr > ADDR_W'(SUB_TOP)) |-> !mem_we);

  // R7
  ro_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && ptr >= ADDR_W'(RO_LO) && ptr <= ADDR_W'(RO_HI)) |-> !mem_we);

  // R9
  split_upd_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && ptr == ADDR_W'(SPLIT_ADDR)) |=> (split_en == $past(wr_data[SPLIT_BIT])));
endmodule

// File: tb/regmap_ctrl_test.sv
module regmap_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic txn_start = 0, txn_stop = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = '0;
  logic rd_valid;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;

  logic [7:0] cmn [64];
  logic [7:0] mb  [256];
  logic [7:0] sb  [256];
  int  m_ptr = 0;
  bit  m_act = 0, m_exp = 0;

  regmap_ctrl uut (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_stop(txn_stop),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit m_split();
    return cmn[14][5];
  endfunction

  function automatic logic [7:0] m_read(int a);
    if (a < 64) begin
      if (a >= 'h10 && a <= 'h13) return 8'(8'hA0 + a - 'h10);
      if (a >= 'h20 && a <= 'h23) return 8'h00;
      return cmn[a];
    end
    if (m_split()) return (a <= 'h9C) ? sb[a] : 8'h00;
    return mb[a];
  endfunction

  task automatic m_write(int a, logic [7:0] d);
    if (a < 64) begin
      if (!(a >= 'h10 && a <= 'h13)) cmn[a] = d;
    end else if (m_split()) begin
      if (a <= 'h9C) sb[a] = d;
    end else mb[a] = d;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive, model, sample one unit after the edge
  task automatic step(bit s, bit p, bit w, logic [7:0] d, bit r, string req);
    logic [7:0] exp_d = '0;
    bit exp_v = 0;
    txn_start = s; txn_stop = p; wr_en = w; wr_data = d; rd_en = r;
    if (s) begin m_act = 1; m_exp = 1; end
    else if (p) begin m_act = 0; m_exp = 0; end
    else if (w && m_act) begin
      if (m_exp) begin m_ptr = d; m_exp = 0; end
      else begin m_write(m_ptr, d); m_ptr = (m_ptr + 1) % 256; end
    end else if (r && m_act) begin
      exp_v = 1; exp_d = m_read(m_ptr); m_ptr = (m_ptr + 1) % 256;
    end
    @(posedge clk); #1;
    txn_start = 0; txn_stop = 0; wr_en = 0; rd_en = 0;
    check(rd_valid == exp_v, req, "rd_valid", int'(rd_valid), int'(exp_v));
    if (exp_v) check(rd_data == exp_d, req, "rd_data", int'(rd_data), int'(exp_d));
  endtask

  task automatic open_at(logic [7:0] a, string req);
    step(1, 0, 0, 0, 0, req);
    step(0, 0, 1, a, 0, req);
  endtask

  task automatic close(string req);
    step(0, 1, 0, 0, 0, req);
  endtask

  task automatic burst_wr(logic [7:0] a, int n, int seed, string req);
    open_at(a, req);
    for (int i = 0; i < n; i++) step(0, 0, 1, 8'(seed + 7 * i), 0, req);
    close(req);
  endtask

  task automatic burst_rd(logic [7:0] a, int n, string req);
    open_at(a, req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, req);
    close(req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mb[i] = 0; sb[i] = 0; end
    for (int i = 0; i < 64; i++) cmn[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check(rd_valid == 1'b0, "R3", "reset rd_valid", int'(rd_valid), 0);
    step(0, 0, 0, 0, 0, "R3");

    // R5: split resets to 0, upper addresses reach main bank
    burst_wr(8'h50, 2, 'h5A, "R5");
    burst_rd(8'h50, 2, "R5");
    burst_wr(8'h9D, 4, 'h31, "R5");
    // R1: pointer byte writes nothing; R2 increment
    burst_wr(8'h04, 3, 'h11, "R1");
    burst_wr(8'h30, 1, 'h99, "R1");
    burst_rd(8'h04, 3, "R1");
    // R2: crossing 0x3F to 0x40 and wrap 0xFF to 0x00
    burst_wr(8'h3E, 4, 'h61, "R2");
    burst_rd(8'h3E, 4, "R2");
    burst_wr(8'hFE, 3, 'hC3, "R2");
    burst_rd(8'hFE, 3, "R2");
    // R7 read-only window, R8 write-only window
    burst_wr(8'h10, 4, 'h44, "R7");
    burst_rd(8'h10, 4, "R7");
    burst_wr(8'h20, 4, 'h55, "R8");
    burst_rd(8'h20, 4, "R8");
    // R9: set split at 0x0E and continue in the same burst past 0x40
    open_at(8'h0E, "R9");
    step(0, 0, 1, 8'h20, 0, "R9");
    for (int a = 'h0F; a <= 'h45; a++) step(0, 0, 1, 8'(a ^ 8'h5C), 0, "R9");
    close("R9");
    burst_rd(8'h40, 6, "R9");
    // R4: common space unchanged under split
    burst_rd(8'h3E, 2, "R4");
    // R6: dead secondary range
    burst_wr(8'h9B, 5, 'h81, "R6");
    burst_rd(8'h9B, 5, "R6");
    // back to main bank: earlier main contents intact
    burst_wr(8'h0E, 1, 0, "R5");
    burst_rd(8'h9D, 4, "R6");
    burst_rd(8'h40, 2, "R5");
    // R10: strobes outside a transaction ignored, held pointer reused
    step(0, 0, 1, 8'hEE, 0, "R10");
    step(0, 0, 0, 0, 1, "R10");
    open_at(8'h05, "R10");
    close("R10");
    step(1, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, 1, "R10");
    close("R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule